// File: doc/BRIEF.md
# Exception Restart PC Capture

This block holds the program counter of a processor core together with the flag that selects the compressed (16-bit) instruction mode. It computes the address at which execution resumes after an exception or a soft reset. A PC write carries the instruction-set mode in its bit 0. That bit is split off into the mode flag, and the stored PC is always even. The same write also says whether the instruction at the new PC sits in a branch delay slot, and whether that branch had a 16-bit encoding.

An exception strobe captures a restart address into the exception PC register. The restart address is the PC with the mode flag in bit 0. When the current instruction sits in a delay slot, the address steps back over the branch: 2 bytes for a 16-bit branch, 4 bytes otherwise. A soft-reset strobe captures the same stepped-back PC, without the mode bit, into the error PC register. It then sends the PC to the boot vector and sets the mode flag from a configuration input.

The delay-slot status is a small state machine with three states. SLOT_NONE means the current PC is not in a delay slot. SLOT_W4 means it follows a 4-byte branch, and SLOT_W2 means it follows a 2-byte branch. A load transition enters SLOT_NONE, SLOT_W4 or SLOT_W2 from the write's flags. A capture transition (exception or soft reset) always returns to SLOT_NONE, and so does hardware reset.

Top module: `restart_pc_unit`

## Requirements
- R1: While rst_n is low, pc_o is the boot vector, epc_o and errpc_o are zero, and isa16_o is 1 exactly when cfg_isa equals 3 (binary 11).
- R2: One cycle after an accepted PC write, pc_o equals pc_wdata with bit 0 cleared and isa16_o equals pc_wdata bit 0. pc_o bit 0 is never 1.
- R3: One cycle after exc_req, when the current PC is not in a delay slot, epc_o equals pc_o with isa16_o placed in bit 0.
- R4: When the current PC was written with wr_slot=1, the captured restart address is reduced by 2 if wr_b16=1 and by 4 if wr_b16=0.
- R5: One cycle after srst_req, errpc_o equals the delay-slot-adjusted pc_o with no mode bit, pc_o equals the boot vector, and isa16_o is 1 exactly when cfg_isa equals 3. errpc_o changes at no other time.
- R6: Every capture clears the delay-slot status, so a second capture with no PC write in between uses no step-back.
- R7: Priority is srst_req over exc_req over pc_we. A write coinciding with either strobe is dropped, and exc_req together with srst_req leaves epc_o unchanged.
- R8: The boot vector is 0xBFC00000 sign-extended to XLEN bits, and all restart arithmetic wraps modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cfg_isa | input | 2 | Reset instruction-set configuration; value 3 starts in compressed mode |
| pc_we | input | 1 | PC write request |
| pc_wdata | input | XLEN | New PC; bit 0 is the compressed-mode flag |
| wr_slot | input | 1 | New PC is a branch delay slot |
| wr_b16 | input | 1 | The branch owning that slot is a 16-bit encoding |
| exc_req | input | 1 | Exception capture strobe |
| srst_req | input | 1 | Soft-reset capture strobe |
| pc_o | output | XLEN | Current PC, always even |
| isa16_o | output | 1 | Compressed-mode flag |
| epc_o | output | XLEN | Saved exception restart address |
| errpc_o | output | XLEN | Saved error PC from the last soft reset |

## Verification
The bench builds the block with XLEN=64 and the default boot vector. This makes the sign extension of 0xBFC00000 into the upper 32 bits observable. It also lets a step-back from address 1 wrap to all ones across the full 64-bit width. Both delay-slot widths are reached, along with repeated captures, coincident strobes, and both values of cfg_isa at hardware and soft reset.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    // Delay-slot status of the instruction at the current PC
    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_W4   = 2'd1,
        SLOT_W2   = 2'd2
    } slot_e;

    localparam logic [31:0] BOOT_VECTOR_32 = 32'hBFC0_0000;
    localparam logic [1:0]  CFG_ISA_COMPRESSED = 2'd3;
endpackage

// File: rtl/rpc_slot_fsm.sv
module rpc_slot_fsm
    import rpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_go,
    input  logic       load_slot,
    input  logic       load_b16,
    input  logic       capture_go,
    output slot_e      state_o,
    output logic [2:0] step_bytes
);
    slot_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (capture_go) begin
            state_d = SLOT_NONE;
        end else if (load_go) begin
            if (!load_slot)    state_d = SLOT_NONE;
            else if (load_b16) state_d = SLOT_W2;
            else               state_d = SLOT_W4;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SLOT_NONE: step_bytes = 3'd0;
            SLOT_W4:   step_bytes = 3'd4;
            SLOT_W2:   step_bytes = 3'd2;
            default:   step_bytes = 3'd0;
        endcase
    end

    assign state_o = state_q;

    // R6: any capture leaves the slot status cleared
    p_clear_after_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture_go |=> state_q == SLOT_NONE);

    // R4: only the three encoded states are ever reached
    p_state_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {SLOT_NONE, SLOT_W4, SLOT_W2});
endmodule

// File: rtl/rpc_restart_calc.sv
module rpc_restart_calc #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic            mode,
    input  logic [2:0]      step_bytes,
    output logic [XLEN-1:0] restart_epc,
    output logic [XLEN-1:0] restart_err
);
    logic [XLEN-1:0] step_x;

    always_comb begin
        step_x      = XLEN'(step_bytes);
        restart_epc = (pc | XLEN'(mode)) - step_x;
        restart_err = pc - step_x;
    end
endmodule

// File: rtl/restart_pc_unit.sv
module restart_pc_unit
    import rpc_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter logic [31:0] BOOT_BASE = BOOT_VECTOR_32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cfg_isa,
    input  logic            pc_we,
    input  logic [XLEN-1:0] pc_wdata,
    input  logic            wr_slot,
    input  logic            wr_b16,
    input  logic            exc_req,
    input  logic            srst_req,
    output logic [XLEN-1:0] pc_o,
    output logic            isa16_o,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] errpc_o
);
    localparam logic [XLEN-1:0] BASE_X = XLEN'($signed(BOOT_BASE));

    logic            srst_go, exc_go, load_go, capture_go, boot_mode;
    logic [2:0]      step_bytes;
    logic [XLEN-1:0] restart_epc, restart_err;
    slot_e           slot_state;

    logic [XLEN-1:0] pc_q, epc_q, err_q;
    logic            mode_q;

    assign srst_go    = srst_req;
    assign exc_go     = exc_req & ~srst_req;
    assign load_go    = pc_we & ~exc_req & ~srst_req;
    assign capture_go = srst_go | exc_go;
    assign boot_mode  = (cfg_isa == CFG_ISA_COMPRESSED);

    rpc_slot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_go    (load_go),
        .load_slot  (wr_slot),
        .load_b16   (wr_b16),
        .capture_go (capture_go),
        .state_o    (slot_state),
        .step_bytes (step_bytes)
    );

    rpc_restart_calc #(.XLEN(XLEN)) u_calc (
        .pc          (pc_q),
        .mode        (mode_q),
        .step_bytes  (step_bytes),
        .restart_epc (restart_epc),
        .restart_err (restart_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= BASE_X;
            mode_q <= boot_mode;
            epc_q  <= '0;
            err_q  <= '0;
        end else if (srst_go) begin
            err_q  <= restart_err;
            pc_q   <= BASE_X;
            mode_q <= boot_mode;
        end else if (exc_go) begin
            epc_q  <= restart_epc;
        end else if (load_go) begin
            pc_q   <= {pc_wdata[XLEN-1:1], 1'b0};
            mode_q <= pc_wdata[0];
        end
    end

    assign pc_o    = pc_q;
    assign isa16_o = mode_q;
    assign epc_o   = epc_q;
    assign errpc_o = err_q;

    // R2: stored PC is always even
    p_pc_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[0] == 1'b0);

    // R2: an accepted write lands one cycle later
    p_load_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && !exc_req && !srst_req) |=>
            (pc_o[XLEN-1:1] == $past(pc_wdata[XLEN-1:1])) && (isa16_o == $past(pc_wdata[0])));

    // R5: soft reset vectors to the boot base
    p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> pc_o == BASE_X);

    // R5: error PC moves only on soft reset
    p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_req |=> $stable(errpc_o));

    // R7: an exception drops a coincident write
    p_exc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !srst_req) |=> $stable(pc_o) && $stable(isa16_o));

    // R7: exception PC moves only on an exception not overridden by soft reset
    p_epc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_req || srst_req) |=> $stable(epc_o));
endmodule

// File: tb/sim_restart_pc_unit.sv
module sim_restart_pc_unit;
    localparam int XLEN = 64;
    localparam logic [63:0] BOOT = 64'hFFFF_FFFF_BFC0_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      cfg_isa = 2'd0;
    logic            pc_we = 1'b0;
    logic [XLEN-1:0] pc_wdata = '0;
    logic            wr_slot = 1'b0;
    logic            wr_b16 = 1'b0;
    logic            exc_req = 1'b0;
    logic            srst_req = 1'b0;
    logic [XLEN-1:0] pc_o, epc_o, errpc_o;
    logic            isa16_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    restart_pc_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_isa(cfg_isa), .pc_we(pc_we),
        .pc_wdata(pc_wdata), .wr_slot(wr_slot), .wr_b16(wr_b16),
        .exc_req(exc_req), .srst_req(srst_req), .pc_o(pc_o),
        .isa16_o(isa16_o), .epc_o(epc_o), .errpc_o(errpc_o)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic hw_reset(input logic [1:0] cfg);
        @(negedge clk);
        rst_n = 1'b0; cfg_isa = cfg;
        repeat (2) @(negedge clk);
        chk("R1 pc", pc_o, BOOT);
        chk("R8 vector sign-extended", pc_o[63:32], 64'hFFFF_FFFF);
        chk("R1 mode", 64'(isa16_o), 64'(cfg == 2'd3));
        chk("R1 epc", epc_o, 0);
        chk("R1 errpc", errpc_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_load(input logic [63:0] v, input logic slot, input logic b16);
        pc_we = 1'b1; pc_wdata = v; wr_slot = slot; wr_b16 = b16;
        @(negedge clk);
        pc_we = 1'b0; wr_slot = 1'b0; wr_b16 = 1'b0;
        chk("R2 pc", pc_o, v & ~64'd1);
        chk("R2 mode", 64'(isa16_o), 64'(v[0]));
    endtask

    task automatic do_exc(input string tag, input logic [63:0] exp);
        exc_req = 1'b1;
        @(negedge clk);
        exc_req = 1'b0;
        chk(tag, epc_o, exp);
    endtask

    task automatic test_plain_exc;
        do_load(64'h1001, 1'b0, 1'b0);
        do_exc("R3 epc no slot", 64'h1001);
    endtask

    task automatic test_slot4_and_clear;
        do_load(64'h2000, 1'b1, 1'b0);
        do_exc("R4 slot 4-byte", 64'h1FFC);
        do_exc("R6 second capture", 64'h2000);
    endtask

    task automatic test_slot2_and_wrap;
        do_load(64'h3001, 1'b1, 1'b1);
        do_exc("R4 slot 2-byte", 64'h2FFF);
        do_load(64'h1, 1'b1, 1'b1);
        do_exc("R8 wrap", 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic test_exc_beats_load;
        do_load(64'h4000, 1'b0, 1'b0);
        pc_we = 1'b1; pc_wdata = 64'h5555; exc_req = 1'b1;
        @(negedge clk);
        pc_we = 1'b0; exc_req = 1'b0;
        chk("R7 epc from old pc", epc_o, 64'h4000);
        chk("R7 write dropped", pc_o, 64'h4000);
    endtask

    task automatic test_soft_reset;
        do_load(64'h6001, 1'b1, 1'b0);
        cfg_isa = 2'd3; srst_req = 1'b1;
        @(negedge clk);
        srst_req = 1'b0;
        chk("R5 errpc", errpc_o, 64'h5FFC);
        chk("R5 pc vector", pc_o, BOOT);
        chk("R5 mode from cfg", 64'(isa16_o), 64'd1);
        chk("R7 epc untouched", epc_o, 64'h4000);
        do_exc("R6 after soft reset", BOOT | 64'd1);
    endtask

    task automatic test_srst_beats_exc;
        do_load(64'h7000, 1'b0, 1'b0);
        cfg_isa = 2'd1; srst_req = 1'b1; exc_req = 1'b1;
        @(negedge clk);
        srst_req = 1'b0; exc_req = 1'b0;
        chk("R7 epc held on srst+exc", epc_o, BOOT | 64'd1);
        chk("R5 errpc", errpc_o, 64'h7000);
        chk("R5 mode cfg 1", 64'(isa16_o), 64'd0);
    endtask

    initial begin
        hw_reset(2'd0);
        test_plain_exc();
        test_slot4_and_clear();
        test_slot2_and_wrap();
        test_exc_beats_load();
        test_soft_reset();
        test_srst_beats_exc();
        hw_reset(2'd3);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule